// File: doc/BRIEF.md
# Execution-Triggered Memory Tile Core

This block is the storage core of one tile in a reconfigurable array. It holds a 1024-word by 16-bit RAM with one read port and one write port. Operands arrive on twelve 17-bit lanes. Each lane carries 16 data bits and an execute-enable (EE) bit. Three static selector inputs decide which lane gives the read address, which gives the write address and which gives the write data. Nothing outside the addressed lanes starts an access. A read or a write happens only when the EE bit of its own address lane is high.

An address word is split into two parts. The low 10 bits index the local RAM. The upper 6 bits form a tag, which is compared with a configured tile identifier. Several tiles that share the same address lanes but hold different identifiers therefore act as one larger memory, and exactly one tile answers each address. A read that fires returns its word on the 17-bit result lane one cycle later, with the result EE bit high for that single cycle. Configuration is held static while the tile runs.

The lanes carry no back-pressure. The EE bit is the only qualifier, and the core always accepts an access in the cycle it is flagged. Anything downstream must take the result in the cycle its EE is high, because the next read overwrites it.

Top module: `mtc_core`

## Requirements
- R1: After reset, `res_ee` is 0 and `res_data` is 0.
- R2: Lane k occupies `lane_data[16k+15:16k]` and `lane_ee[k]`. When the lane chosen by `sel_raddr` has EE=1 and its bits [15:10] equal `tile_id`, `res_data` shows the word at index bits [9:0] in the next cycle, and `res_ee` is 1 for that cycle. This holds across the full index range 0 to 1023.
- R3: When the lane chosen by `sel_waddr` has EE=1 and its bits [15:10] equal `tile_id`, the data bits of the lane chosen by `sel_wdata` are stored at index bits [9:0] on that clock edge. The EE bit of the write-data lane has no effect.
- R4: When the tag does not match, a read does not fire and a write does not commit.
- R5: When the EE bit of the write-address lane is 0, memory is unchanged.
- R6: A read and a write to different indices in the same cycle are both performed.
- R7: A read and a write to the same index in the same cycle return the old word, and a later read returns the new word.
- R8: In a cycle after no read fired, `res_ee` is 0 and `res_data` keeps its last value.
- R9: Selector values 12 to 15 choose no lane. A read or write addressed that way does not fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lane_data | input | 192 | Data bits of the 12 input lanes, lane k at [16k+15:16k] |
| lane_ee | input | 12 | Execute-enable bits of the input lanes |
| sel_raddr | input | 4 | Lane that supplies the read address |
| sel_waddr | input | 4 | Lane that supplies the write address |
| sel_wdata | input | 4 | Lane that supplies the write data |
| tile_id | input | 6 | Identifier compared with address bits [15:10] |
| res_data | output | 16 | Registered read data |
| res_ee | output | 1 | High for one cycle when `res_data` holds a new read result |

## Verification
The properties assume the selectors and `tile_id` are held steady in each clock cycle. They also assume lane values are settled before each rising edge, so a firing decision depends only on the sampled inputs. The bench changes lanes and configuration only on falling edges and clears every lane after each access. This keeps each EE pulse to one cycle and avoids cycles in which two accesses blur together.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  localparam int unsigned LANES_DEF  = 12;
  localparam int unsigned WORD_W_DEF = 16;
  localparam int unsigned INDEX_W_DEF = 10;

  // One memory request after lane selection and tag decode.
  typedef struct packed {
    logic        fire;
    logic [15:0] word;
  } req_probe_t;

  function automatic bit lane_in_range(input int unsigned sel, input int unsigned lanes);
    return sel < lanes;
  endfunction
endpackage

// File: rtl/mtc_lane_pick.sv
module mtc_lane_pick #(
  parameter int unsigned LANES = 12,
  parameter int unsigned W     = 16,
  parameter int unsigned SEL_W = $clog2(LANES)
) (
  input  logic [LANES*W-1:0] bus_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic [W-1:0]       lane_o
);
  logic [LANES-1:0] hit;

  // One-hot decode of the selector; out-of-range values give no hit.
  for (genvar k = 0; k < LANES; k++) begin : g_hit
    assign hit[k] = (int'(sel_i) == k);
  end

  always_comb begin
    lane_o = '0;
    for (int k = 0; k < LANES; k++) begin
      if (hit[k]) lane_o = bus_i[k*W +: W];
    end
  end
endmodule

// File: rtl/mtc_tag_gate.sv
module mtc_tag_gate #(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned INDEX_W = 10,
  localparam int unsigned TAG_W  = WORD_W - INDEX_W
) (
  input  logic               ee_i,
  input  logic [WORD_W-1:0]  word_i,
  input  logic [TAG_W-1:0]   tile_id_i,
  output logic               fire_o,
  output logic [INDEX_W-1:0] index_o
);
  logic [TAG_W-1:0] tag;

  assign tag     = word_i[WORD_W-1:INDEX_W];
  assign index_o = word_i[INDEX_W-1:0];
  assign fire_o  = ee_i && (tag == tile_id_i);
endmodule

// File: rtl/mtc_word_store.sv
module mtc_word_store #(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned INDEX_W = 10,
  localparam int unsigned DEPTH  = 1 << INDEX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [INDEX_W-1:0] widx_i,
  input  logic [WORD_W-1:0]  wdata_i,
  input  logic               re_i,
  input  logic [INDEX_W-1:0] ridx_i,
  output logic [WORD_W-1:0]  rdata_o,
  output logic               rvalid_o
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[widx_i] <= wdata_i;
  end

  // Read samples the array before this edge's write lands: old data on collision.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= re_i;
      if (re_i) rdata_o <= mem[ridx_i];
    end
  end

  // R8: an idle cycle leaves the result register untouched
  a_r8_store_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !re_i |=> (!rvalid_o && $stable(rdata_o)));
endmodule

// File: rtl/mtc_core.sv
module mtc_core #(
  parameter int unsigned LANES   = mtc_pkg::LANES_DEF,
  parameter int unsigned WORD_W  = mtc_pkg::WORD_W_DEF,
  parameter int unsigned INDEX_W = mtc_pkg::INDEX_W_DEF,
  parameter int unsigned SEL_W   = $clog2(LANES),
  parameter int unsigned TAG_W   = WORD_W - INDEX_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES*WORD_W-1:0] lane_data,
  input  logic [LANES-1:0]        lane_ee,
  input  logic [SEL_W-1:0]        sel_raddr,
  input  logic [SEL_W-1:0]        sel_waddr,
  input  logic [SEL_W-1:0]        sel_wdata,
  input  logic [TAG_W-1:0]        tile_id,
  output logic [WORD_W-1:0]       res_data,
  output logic                    res_ee
);
  logic [WORD_W-1:0]  ra_word, wa_word, wd_word;
  logic               ra_ee, wa_ee;
  logic               rd_fire, wr_fire;
  logic [INDEX_W-1:0] rd_idx, wr_idx;

  mtc_lane_pick #(.LANES(LANES), .W(WORD_W), .SEL_W(SEL_W)) i_pick_ra (
    .bus_i(lane_data), .sel_i(sel_raddr), .lane_o(ra_word));
  mtc_lane_pick #(.LANES(LANES), .W(WORD_W), .SEL_W(SEL_W)) i_pick_wa (
    .bus_i(lane_data), .sel_i(sel_waddr), .lane_o(wa_word));
  mtc_lane_pick #(.LANES(LANES), .W(WORD_W), .SEL_W(SEL_W)) i_pick_wd (
    .bus_i(lane_data), .sel_i(sel_wdata), .lane_o(wd_word));
  mtc_lane_pick #(.LANES(LANES), .W(1), .SEL_W(SEL_W)) i_pick_ra_ee (
    .bus_i(lane_ee), .sel_i(sel_raddr), .lane_o(ra_ee));
  mtc_lane_pick #(.LANES(LANES), .W(1), .SEL_W(SEL_W)) i_pick_wa_ee (
    .bus_i(lane_ee), .sel_i(sel_waddr), .lane_o(wa_ee));

  mtc_tag_gate #(.WORD_W(WORD_W), .INDEX_W(INDEX_W)) i_gate_rd (
    .ee_i(ra_ee), .word_i(ra_word), .tile_id_i(tile_id),
    .fire_o(rd_fire), .index_o(rd_idx));
  mtc_tag_gate #(.WORD_W(WORD_W), .INDEX_W(INDEX_W)) i_gate_wr (
    .ee_i(wa_ee), .word_i(wa_word), .tile_id_i(tile_id),
    .fire_o(wr_fire), .index_o(wr_idx));

  mtc_word_store #(.WORD_W(WORD_W), .INDEX_W(INDEX_W)) i_store (
    .clk(clk), .rst_n(rst_n),
    .we_i(wr_fire), .widx_i(wr_idx), .wdata_i(wd_word),
    .re_i(rd_fire), .ridx_i(rd_idx),
    .rdata_o(res_data), .rvalid_o(res_ee));

  // R2: a flagged, matching read shows up as a one-cycle result strobe
  a_r2_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> res_ee);
  // R4: a tag mismatch on the read lane never yields a result
  a_r4_tag_block: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_word[WORD_W-1:INDEX_W] != tile_id) |=> !res_ee);
  // R9: an out-of-range read selector never yields a result
  a_r9_bad_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel_raddr) >= LANES) |=> !res_ee);
  // R5: a write never fires without the write-address lane's EE
  a_r5_wr_needs_ee: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> wa_ee);
endmodule

// File: tb/test_mtc_core.sv
module test_mtc_core;
  localparam int LANES = 12;
  localparam int RL = 2, WL = 5, DL = 7;
  localparam logic [5:0] ID = 6'h2A;

  logic clk = 0, rst_n = 0;
  logic [LANES*16-1:0] lane_data = '0;
  logic [LANES-1:0] lane_ee = '0;
  logic [3:0] sel_raddr = 4'(RL), sel_waddr = 4'(WL), sel_wdata = 4'(DL);
  logic [5:0] tile_id = ID;
  logic [15:0] res_data;
  logic res_ee;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mtc_core i_mtc_core (.clk(clk), .rst_n(rst_n), .lane_data(lane_data), .lane_ee(lane_ee),
    .sel_raddr(sel_raddr), .sel_waddr(sel_waddr), .sel_wdata(sel_wdata),
    .tile_id(tile_id), .res_data(res_data), .res_ee(res_ee));

  task automatic chk(string req, logic [16:0] act, logic [16:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // One access cycle on fixed lanes; sampled on the next falling edge.
  task automatic cyc(bit re, logic [15:0] ra, bit we, logic [15:0] wa, logic [15:0] wd, bit wd_ee);
    lane_data[RL*16 +: 16] = ra; lane_ee[RL] = re;
    lane_data[WL*16 +: 16] = wa; lane_ee[WL] = we;
    lane_data[DL*16 +: 16] = wd; lane_ee[DL] = wd_ee;
    @(negedge clk);
    lane_data = '0; lane_ee = '0;
  endtask

  function automatic logic [15:0] adr(logic [5:0] t, logic [9:0] i);
    return {t, i};
  endfunction

  task automatic t_reset;
    chk("R1 ee", {16'h0, res_ee}, 17'h0);
    chk("R1 data", {1'b0, res_data}, 17'h0);
  endtask

  task automatic t_basic;
    cyc(0, 0, 1, adr(ID, 10'h005), 16'hBEEF, 0);
    cyc(1, adr(ID, 10'h005), 0, 0, 0, 0);
    chk("R2/R3 read", {res_ee, res_data}, {1'b1, 16'hBEEF});
    cyc(0, 0, 0, 0, 0, 0);
    chk("R8 idle hold", {res_ee, res_data}, {1'b0, 16'hBEEF});
    cyc(0, 0, 1, adr(ID, 10'h3FF), 16'hA5C3, 1);
    cyc(1, adr(ID, 10'h3FF), 0, 0, 0, 0);
    chk("R2 top index", {res_ee, res_data}, {1'b1, 16'hA5C3});
    cyc(0, 0, 1, adr(ID, 10'h000), 16'h0F0F, 0);
    cyc(1, adr(ID, 10'h000), 0, 0, 0, 0);
    chk("R2 index zero", {res_ee, res_data}, {1'b1, 16'h0F0F});
  endtask

  task automatic t_tag;
    cyc(0, 0, 1, adr(6'h15, 10'h005), 16'h1111, 0);
    cyc(1, adr(6'h15, 10'h005), 0, 0, 0, 0);
    chk("R4 read mismatch", {res_ee, res_data}, {1'b0, 16'h0F0F});
    cyc(1, adr(ID, 10'h005), 0, 0, 0, 0);
    chk("R4 write mismatch", {res_ee, res_data}, {1'b1, 16'hBEEF});
  endtask

  task automatic t_ee_low;
    cyc(0, 0, 0, adr(ID, 10'h005), 16'h2222, 1);
    cyc(1, adr(ID, 10'h005), 0, 0, 0, 0);
    chk("R5 no write", {res_ee, res_data}, {1'b1, 16'hBEEF});
  endtask

  task automatic t_dual;
    cyc(1, adr(ID, 10'h005), 1, adr(ID, 10'h009), 16'h0909, 0);
    chk("R6 read side", {res_ee, res_data}, {1'b1, 16'hBEEF});
    cyc(1, adr(ID, 10'h009), 0, 0, 0, 0);
    chk("R6 write side", {res_ee, res_data}, {1'b1, 16'h0909});
  endtask

  task automatic t_same;
    cyc(1, adr(ID, 10'h005), 1, adr(ID, 10'h005), 16'h5555, 0);
    chk("R7 old data", {res_ee, res_data}, {1'b1, 16'hBEEF});
    cyc(1, adr(ID, 10'h005), 0, 0, 0, 0);
    chk("R7 new data", {res_ee, res_data}, {1'b1, 16'h5555});
  endtask

  task automatic t_bad_sel;
    sel_raddr = 4'd13;
    cyc(1, adr(ID, 10'h005), 0, 0, 0, 0);
    chk("R9 read none", {res_ee, res_data}, {1'b0, 16'h5555});
    sel_raddr = 4'(RL); sel_waddr = 4'd14;
    cyc(0, 0, 1, adr(ID, 10'h005), 16'h7777, 0);
    sel_waddr = 4'(WL);
    cyc(1, adr(ID, 10'h005), 0, 0, 0, 0);
    chk("R9 write none", {res_ee, res_data}, {1'b1, 16'h5555});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_tag;
    t_ee_low;
    t_dual;
    t_same;
    t_bad_sel;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int n = 0; n < 100000; n++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule